// File: doc/BRIEF.md
# Two-Byte Instruction Prefetch Buffer

This block sits between a byte-wide instruction fetch port of a processor core and a program memory that is 16 bits wide and takes two clock cycles per read. Each memory read returns an aligned pair of bytes. While prefetch is on, the block requests the next pair while the core is still consuming the current one. Straight-line code therefore receives one byte per cycle after the first pair has arrived.

When the core redirects the fetch stream, the block drops everything it holds for the old path. It reads the pair that contains the target and hands over the target byte in the third cycle, counting the redirect cycle as the first. A control register at address 0xAF holds an enable flag that comes out of reset set. When the flag is cleared, speculative reads stop and every byte is fetched on demand, for example before the chip enters a low-power state.

Top module: `prefetch_pair_buffer`

## Requirements
- R1: After reset, the enable flag is 1, so the control register reads 0x20. `cpu_valid` is 0, and `mem_rd` is 0 while `cpu_req` is 0.
- R2: With prefetch enabled, a sequential run that starts at an even address delivers one byte per cycle once its first byte has been delivered. The run costs 2 stall cycles in total.
- R3: When `cpu_branch` and `cpu_req` are high together, and the core then holds the same address without a further branch, `cpu_valid` rises in the third cycle counted from the branch cycle. That is at most two stall cycles.
- R4: A branch to an odd address reads the containing pair and delivers its upper byte. With prefetch enabled, one extra stall follows before the next pair, so a sequential run of two or more bytes from an odd target costs 3 stall cycles.
- R5: No byte is delivered in a branch cycle. Buffered bytes and reads still in flight for the old path are discarded, even when the target lies in the pair just buffered. Every delivered byte matches memory, and none is delivered that was not requested.
- R6: `mem_addr` is the byte address shifted right by one. The byte at an even address is `mem_data[7:0]` and the byte at the odd address is `mem_data[15:8]`. `mem_valid` with the data follows `mem_rd` by exactly two cycles.
- R7: Writing to address 0xAF sets the enable flag from data bit 5. The register reads back 0x20 or 0x00, writes to its other bits are ignored, other addresses read 0x00, and writes to other addresses leave the flag unchanged.
- R8: With prefetch disabled, a read is issued only while the core requests a byte that has not arrived. Each byte then costs 2 stall cycles and one memory read, and an idle core causes no reads.
- R9: After prefetch is enabled again, a run from an even address is back to 2 stall cycles in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Core requests the byte at `cpu_addr` |
| cpu_branch | input | 1 | Fetch redirect strobe; `cpu_addr` is the new target |
| cpu_addr | input | AW | Byte address of the requested instruction byte |
| cpu_byte | output | 8 | Delivered instruction byte |
| cpu_valid | output | 1 | `cpu_byte` holds the byte at `cpu_addr` in this cycle |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 8 | Control register address |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data (combinational) |
| mem_rd | output | 1 | Program memory read strobe |
| mem_addr | output | AW-1 | Pair index of the read |
| mem_data | input | 16 | Pair returned by memory |
| mem_valid | input | 1 | `mem_data` holds the pair read two cycles earlier |

## Verification
The assertions assume that memory answers every read exactly two cycles later. They also assume that a stalled core holds its address and request steady and raises the redirect strobe for a single cycle only. The bench memory model is a fixed two-stage pipeline. The core driver changes its address only after a cycle with `cpu_valid` high, and pulses `cpu_branch` only in the first cycle of each run. Control register writes are made only while the core is idle.

// File: rtl/prefetch_pair_buffer.sv
module prefetch_pair_buffer #(
  parameter int          AW        = 16,
  parameter logic [7:0]  CTRL_ADDR = 8'hAF,
  parameter int          EN_BIT    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_branch,
  input  logic [AW-1:0] cpu_addr,
  output logic [7:0]    cpu_byte,
  output logic          cpu_valid,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  output logic          mem_rd,
  output logic [AW-2:0] mem_addr,
  input  logic [15:0]   mem_data,
  input  logic          mem_valid
);
  localparam int PW = AW - 1;
  localparam logic [PW-1:0] ONE = PW'(1);
  localparam logic [7:0] EN_MASK = 8'(1) << EN_BIT;

  logic          en;
  logic          buf_v;
  logic [PW-1:0] buf_pair;
  logic [15:0]   buf_data;
  logic [1:0]    q_v;
  logic [PW-1:0] q_pair [2];

  wire [PW-1:0] want    = cpu_addr[AW-1:1];
  wire          rsp     = q_v[1] && mem_valid && !cpu_branch;
  wire          rsp_hit = rsp && (q_pair[1] == want);
  wire          buf_hit = en && buf_v && !cpu_branch && (buf_pair == want);
  wire          hit     = cpu_req && (rsp_hit || buf_hit);
  wire [15:0]   src     = rsp_hit ? mem_data : buf_data;
  wire          covered = q_v[0] && !cpu_branch && (q_pair[0] == want);
  wire          demand  = cpu_req && !hit && !covered;
  wire          pf      = en && hit && !q_v[0];

  assign cpu_valid = hit;
  assign cpu_byte  = cpu_addr[0] ? src[15:8] : src[7:0];
  assign mem_rd    = demand || pf;
  assign mem_addr  = demand ? want : want + ONE;
  assign cfg_rdata = (cfg_addr == CTRL_ADDR && en) ? EN_MASK : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b1;
      buf_v <= 1'b0;
      q_v   <= 2'b00;
    end else begin
      if (cfg_we && cfg_addr == CTRL_ADDR)
        en <= (cfg_wdata & EN_MASK) != 8'h00;
      if (cpu_branch)
        buf_v <= 1'b0;
      else if (rsp) begin
        buf_v    <= 1'b1;
        buf_pair <= q_pair[1];
        buf_data <= mem_data;
      end
      q_v[0] <= mem_rd;
      q_v[1] <= q_v[0] && !cpu_branch;
    end
    q_pair[0] <= mem_addr;
    q_pair[1] <= q_pair[0];
  end

  a_r5_no_byte_on_branch: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_branch |-> !cpu_valid);

  a_r3_branch_two_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_branch && cpu_req, 2) && !$past(cpu_branch) && $past(cpu_req) &&
    cpu_req && !cpu_branch && $stable(cpu_addr) && $past(cpu_addr) == $past(cpu_addr, 2)
    |-> cpu_valid);

  a_r8_no_speculation: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && mem_rd) |-> (cpu_req && !cpu_valid));

  a_r6_mem_latency: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $past(mem_rd, 2));
endmodule

// File: tb/sim_prefetch_pair_buffer.sv
module sim_prefetch_pair_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_branch = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_byte;
  logic        cpu_valid;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'hAF, cfg_wdata = '0, cfg_rdata;
  logic        mem_rd;
  logic [14:0] mem_addr;
  logic [15:0] mem_data;
  logic        mem_valid;

  int checks = 0, fails = 0, rdcnt = 0;
  logic [7:0] expq [$];

  always #10 clk = ~clk;

  prefetch_pair_buffer u0 (.*);

  function automatic logic [7:0] img(input logic [15:0] a);
    return (a[7:0] * 8'd13) ^ (a[15:8] + 8'h5A);
  endfunction

  logic [1:0]  mv;
  logic [14:0] ma [2];
  always @(posedge clk) begin
    if (!rst_n) mv <= 2'b00;
    else mv <= {mv[0], mem_rd};
    ma[0] <= mem_addr;
    ma[1] <= ma[0];
  end
  assign mem_valid = mv[1];
  assign mem_data  = mv[1] ? {img({ma[1], 1'b1}), img({ma[1], 1'b0})} : 16'hDEAD;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_rd) rdcnt++;
    if (rst_n && cpu_valid) begin
      if (expq.size() == 0) chk(1'b0, "R5 unrequested byte", cpu_byte, 0);
      else begin
        automatic logic [7:0] e = expq.pop_front();
        chk(cpu_byte == e, "R6 byte", cpu_byte, e);
      end
    end
  end

  task automatic run(input logic [15:0] start, input int n, output int stalls);
    automatic logic [15:0] a = start;
    automatic bit fresh = 1'b1, br = 1'b1;
    automatic int k = 0;
    stalls = 0;
    while (k < n) begin
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_branch = br; cpu_addr = a;
      if (fresh) expq.push_back(img(a));
      fresh = 1'b0; br = 1'b0;
      @(negedge clk);
      if (cpu_valid) begin a++; k++; fresh = 1'b1; end
      else stalls++;
    end
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1; cpu_req = 1'b0; cpu_branch = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] ad, input logic [7:0] d);
    @(posedge clk); #1; cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 1'b0; cfg_addr = 8'hAF;
  endtask

  task automatic cfg_check(input logic [7:0] ad, input logic [7:0] exp, input string req);
    @(posedge clk); #1; cfg_addr = ad;
    @(negedge clk);
    chk(cfg_rdata == exp, req, cfg_rdata, exp);
    cfg_addr = 8'hAF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int s, r0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(cpu_valid == 1'b0, "R1 valid", cpu_valid, 0);
    chk(mem_rd == 1'b0, "R1 mem_rd", mem_rd, 0);
    chk(cfg_rdata == 8'h20, "R1 ctrl", cfg_rdata, 8'h20);
    @(posedge clk); #1; rst_n = 1'b1;

    run(16'h0100, 16, s); chk(s == 2, "R2 linear stalls", s, 2);
    run(16'h0251, 9, s);  chk(s == 3, "R4 odd run stalls", s, 3);
    run(16'h0258, 4, s);  chk(s == 2, "R5 branch into buffered pair", s, 2);
    run(16'h0301, 1, s);  chk(s == 2, "R3 odd single", s, 2);
    run(16'h0600, 3, s);  chk(s == 2, "R3 short run", s, 2);
    run(16'h0700, 5, s);  chk(s == 2, "R5 branch mid-stream", s, 2);
    idle(4);

    cfg_write(8'hAF, 8'h00);
    cfg_check(8'hAF, 8'h00, "R7 cleared");
    r0 = rdcnt;
    run(16'h0400, 6, s);
    chk(s == 12, "R8 disabled stalls", s, 12);
    chk(rdcnt - r0 == 6, "R8 one read per byte", rdcnt - r0, 6);
    idle(2);
    r0 = rdcnt;
    repeat (10) @(posedge clk);
    chk(rdcnt == r0, "R8 idle no reads", rdcnt - r0, 0);

    cfg_write(8'hAF, 8'hDF);
    cfg_check(8'hAF, 8'h00, "R7 other bits ignored");
    cfg_write(8'hAE, 8'hFF);
    cfg_check(8'hAF, 8'h00, "R7 other address write");
    cfg_check(8'hAE, 8'h00, "R7 other address read");
    cfg_write(8'hAF, 8'h20);
    cfg_check(8'hAF, 8'h20, "R7 set");
    cfg_write(8'h00, 8'h00);
    cfg_check(8'hAF, 8'h20, "R7 flag kept");

    run(16'h0500, 10, s); chk(s == 2, "R9 re-enabled", s, 2);
    run(16'h0533, 4, s);  chk(s == 3, "R4 odd after re-enable", s, 3);
    idle(4);
    chk(expq.size() == 0, "R5 all bytes delivered", expq.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule